// File: doc/BRIEF.md
# Multidrop Serial Receiver with Station Address Filter

This block receives asynchronous serial frames on a shared multidrop line. After a low start bit it collects eight data bits, least significant first, then, depending on the selected format, a ninth bit, then a stop bit. The line is sampled on a bit-rate tick at sixteen ticks per bit. Each bit is decided by a majority vote of the three samples nearest the middle of the bit.

A two-bit format selector picks the frame layout. With the multiprocessor filter enabled, the receiver raises its done flag only for frames of interest. In the nine-bit formats these are address frames (ninth bit 1) whose byte equals the programmed station address. In the eight-bit format these are frames with a valid stop bit. Software polls or takes an interrupt from the done flag, reads the byte, and clears the flag with a pulse. A separate sticky flag reports stop-bit errors.

Top module: `mdropRx`

## Requirements
- R1: With modeSel = 1 (eight data bits), the byte received least significant bit first appears on rxData. rxDone is set at the end of the stop bit.
- R2: With modeSel = 2 or 3 (nine bits), the received ninth bit appears on rxBit9 together with the byte.
- R3: With modeSel = 1 and mpFilter = 0, the sampled stop bit is stored on rxBit9, and the frame is accepted even when that bit is 0.
- R4: With modeSel = 1 and mpFilter = 1, a frame whose stop bit is 0 leaves rxDone, rxData and rxBit9 unchanged.
- R5: With modeSel = 2 or 3 and mpFilter = 1, a frame whose ninth bit is 0 leaves rxDone, rxData and rxBit9 unchanged.
- R6: With modeSel = 2 or 3 and mpFilter = 1, a frame is accepted only when its ninth bit is 1 and its byte equals stationAddr. Any other byte is ignored.
- R7: While rxEnable = 0, or while modeSel = 0, no frame is received and all outputs hold. Dropping rxEnable during a frame aborts that frame.
- R8: frameErr is set whenever a frame's sampled stop bit is 0, whether or not the frame is accepted. It stays set until a ferrClr pulse clears it.
- R9: rxDone stays set until a doneClr pulse. A frame accepted while rxDone is already set keeps the flag set and overwrites rxData and rxBit9. If a flag is set and cleared in the same cycle, the set takes effect.
- R10: A disturbance that corrupts only one of the three mid-bit samples does not change the received bit.
- R11: A low pulse on rxIn shorter than half a bit, seen as a start bit, is rejected at mid-bit. The receiver returns to idle and no frame results.
- R12: After reset, rxData = 0, rxBit9 = 0, rxDone = 0 and frameErr = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxIn | input | 1 | Serial line, idle high |
| bitTick | input | 1 | One-cycle pulse at sixteen times the bit rate |
| modeSel | input | 2 | Frame format: 0 off, 1 eight-bit, 2 or 3 nine-bit |
| rxEnable | input | 1 | Reception enable |
| mpFilter | input | 1 | Multiprocessor filter enable |
| stationAddr | input | 8 | Programmed station address |
| doneClr | input | 1 | Pulse that clears rxDone |
| ferrClr | input | 1 | Pulse that clears frameErr |
| rxData | output | 8 | Last accepted byte |
| rxBit9 | output | 1 | Ninth bit, or stop bit in eight-bit format |
| rxDone | output | 1 | Sticky frame-accepted flag |
| frameErr | output | 1 | Sticky stop-bit error flag |

## Verification
The assertions assume three things about the inputs. modeSel, mpFilter and stationAddr stay constant while a frame is in flight. bitTick is a single-cycle pulse. rxIn changes no faster than the tick rate, apart from deliberate glitches. The stimulus meets these assumptions by changing configuration only on an idle line, between frames. It generates the tick from a fixed divider of four clocks and holds every bit for exactly sixteen ticks. Glitches last one tick, so that at most one vote sample is hit.

// File: rtl/mdropRxPkg.sv
package mdropRxPkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_BIT9,
    ST_STOP
  } rxStateT;

  typedef struct packed {
    logic sample;   // take one mid-bit sample
    logic shift;    // shift voted data bit in
    logic capBit9;  // store voted ninth bit
    logic capStop;  // store voted stop bit
    logic finish;   // end of stop bit: qualify frame
  } rxStrbT;
endpackage

// File: rtl/mdropRxCtrl.sv
module mdropRxCtrl
  import mdropRxPkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitTick,
  input  logic       rxS,
  input  logic       vote,
  input  logic       rxEnable,
  input  logic [1:0] modeSel,
  output rxStrbT     strb
);
  localparam int CW  = $clog2(OVS);
  localparam int IW  = $clog2(DW);
  localparam int MID = OVS / 2;
  localparam logic [CW-1:0] SMP_LO = CW'(MID - 1);
  localparam logic [CW-1:0] SMP_MD = CW'(MID);
  localparam logic [CW-1:0] SMP_HI = CW'(MID + 1);
  localparam logic [CW-1:0] DECIDE = CW'(MID + 2);
  localparam logic [CW-1:0] LAST   = CW'(OVS - 1);
  localparam logic [IW-1:0] LASTBIT = IW'(DW - 1);

  rxStateT       state;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic          active, busy, decide, endBit, nineBit;

  assign active  = rxEnable && (modeSel != 2'd0);
  assign busy    = active && bitTick && (state != ST_IDLE);
  assign decide  = busy && (cnt == DECIDE);
  assign endBit  = busy && (cnt == LAST);
  assign nineBit = modeSel[1];

  always_comb begin
    strb         = '0;
    strb.sample  = busy && (cnt == SMP_LO || cnt == SMP_MD || cnt == SMP_HI);
    strb.shift   = decide && (state == ST_DATA);
    strb.capBit9 = decide && (state == ST_BIT9);
    strb.capStop = decide && (state == ST_STOP);
    strb.finish  = endBit && (state == ST_STOP);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      idx   <= '0;
    end else if (!active) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (bitTick) begin
      if (state == ST_IDLE) begin
        if (!rxS) begin
          state <= ST_START;
          cnt   <= '0;
        end
      end else begin
        cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        unique case (state)
          ST_START: begin
            if (decide && vote) state <= ST_IDLE;
            else if (endBit) begin
              state <= ST_DATA;
              idx   <= '0;
            end
          end
          ST_DATA: begin
            if (endBit) begin
              if (idx == LASTBIT) state <= nineBit ? ST_BIT9 : ST_STOP;
              else idx <= idx + 1'b1;
            end
          end
          ST_BIT9: if (endBit) state <= ST_STOP;
          ST_STOP: if (endBit) state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R7
  enable_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && !rxEnable) |=> (state == ST_IDLE));

  // R11
  start_glitch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_START && decide && vote) |=> (state == ST_IDLE));
endmodule

// File: rtl/mdropRxData.sv
module mdropRxData
  import mdropRxPkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rxIn,
  input  rxStrbT        strb,
  input  logic [1:0]    modeSel,
  input  logic          mpFilter,
  input  logic [DW-1:0] stationAddr,
  input  logic          doneClr,
  input  logic          ferrClr,
  output logic          rxS,
  output logic          vote,
  output logic [DW-1:0] rxData,
  output logic          rxBit9,
  output logic          rxDone,
  output logic          frameErr
);
  logic          syncA;
  logic [2:0]    samp;
  logic [DW-1:0] shiftReg;
  logic          bit9Reg, stopReg, accept, nineBit;

  assign vote    = (samp[0] & samp[1]) | (samp[0] & samp[2]) | (samp[1] & samp[2]);
  assign nineBit = modeSel[1];

  always_comb begin
    if (!mpFilter)   accept = 1'b1;
    else if (nineBit) accept = bit9Reg && (shiftReg == stationAddr);
    else              accept = stopReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA    <= 1'b1;
      rxS      <= 1'b1;
      samp     <= '1;
      shiftReg <= '0;
      bit9Reg  <= 1'b0;
      stopReg  <= 1'b1;
      rxData   <= '0;
      rxBit9   <= 1'b0;
      rxDone   <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      syncA <= rxIn;
      rxS   <= syncA;
      if (strb.sample)  samp     <= {samp[1:0], rxS};
      if (strb.shift)   shiftReg <= {vote, shiftReg[DW-1:1]};
      if (strb.capBit9) bit9Reg  <= vote;
      if (strb.capStop) stopReg  <= vote;
      if (strb.finish && accept) begin
        rxData <= shiftReg;
        rxBit9 <= nineBit ? bit9Reg : stopReg;
      end
      if (strb.finish && accept) rxDone <= 1'b1;
      else if (doneClr)          rxDone <= 1'b0;
      if (strb.finish && !stopReg) frameErr <= 1'b1;
      else if (ferrClr)            frameErr <= 1'b0;
    end
  end

  // R9
  done_on_finish_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxDone) |-> $past(strb.finish));

  // R8
  ferr_on_finish_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameErr) |-> $past(strb.finish));

  // R5
  nine_zero_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finish && mpFilter && nineBit && !bit9Reg) |=> ($stable(rxData) && $stable(rxBit9)));

  // R4
  bad_stop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finish && mpFilter && !nineBit && !stopReg) |=> ($stable(rxData) && $stable(rxBit9)));
endmodule

// File: rtl/mdropRx.sv
module mdropRx
  import mdropRxPkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rxIn,
  input  logic          bitTick,
  input  logic [1:0]    modeSel,
  input  logic          rxEnable,
  input  logic          mpFilter,
  input  logic [DW-1:0] stationAddr,
  input  logic          doneClr,
  input  logic          ferrClr,
  output logic [DW-1:0] rxData,
  output logic          rxBit9,
  output logic          rxDone,
  output logic          frameErr
);
  rxStrbT strb;
  logic   rxS, vote;

  mdropRxCtrl #(.OVS(OVS), .DW(DW)) ctrl_i (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .rxS(rxS), .vote(vote),
    .rxEnable(rxEnable), .modeSel(modeSel), .strb(strb)
  );

  mdropRxData #(.DW(DW)) data_i (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .strb(strb), .modeSel(modeSel),
    .mpFilter(mpFilter), .stationAddr(stationAddr), .doneClr(doneClr),
    .ferrClr(ferrClr), .rxS(rxS), .vote(vote), .rxData(rxData),
    .rxBit9(rxBit9), .rxDone(rxDone), .frameErr(frameErr)
  );
endmodule

// File: tb/mdropRx_tb_top.sv
module mdropRx_tb_top;
  localparam int BITCLK = 64;  // 16 ticks of 4 clocks
  localparam logic [7:0] ADDR = 8'h5A;

  logic clk = 1'b0, rstN = 1'b0, rxIn = 1'b1, bitTick = 1'b0;
  logic [1:0] modeSel = 2'd1;
  logic rxEnable = 1'b1, mpFilter = 1'b0, doneClr = 1'b0, ferrClr = 1'b0;
  logic [7:0] stationAddr = ADDR;
  logic [7:0] rxData;
  logic rxBit9, rxDone, frameErr;
  logic [1:0] tickDiv = 2'd0;
  int nChk = 0, nFail = 0;
  logic [7:0] mData = 8'h00;
  logic mB9 = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) begin
    tickDiv <= tickDiv + 2'd1;
    bitTick <= (tickDiv == 2'd3);
  end

  mdropRx dut_i (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .bitTick(bitTick), .modeSel(modeSel),
    .rxEnable(rxEnable), .mpFilter(mpFilter), .stationAddr(stationAddr),
    .doneClr(doneClr), .ferrClr(ferrClr), .rxData(rxData), .rxBit9(rxBit9),
    .rxDone(rxDone), .frameErr(frameErr)
  );

  // {mode, filter, enable, data, bit9, stop, expectLoad, expectFerr}
  localparam logic [15:0] VEC [12] = '{
    {2'd1, 1'b0, 1'b1, 8'hA5, 1'b0, 1'b1, 1'b1, 1'b0},  // R1
    {2'd1, 1'b0, 1'b1, 8'h3C, 1'b0, 1'b0, 1'b1, 1'b1},  // R3 R8
    {2'd1, 1'b1, 1'b1, 8'h77, 1'b0, 1'b0, 1'b0, 1'b1},  // R4
    {2'd1, 1'b1, 1'b1, 8'h81, 1'b0, 1'b1, 1'b1, 1'b0},  // R4 accept
    {2'd2, 1'b0, 1'b1, 8'hC3, 1'b0, 1'b1, 1'b1, 1'b0},  // R2
    {2'd3, 1'b0, 1'b1, 8'h12, 1'b1, 1'b1, 1'b1, 1'b0},  // R2
    {2'd2, 1'b1, 1'b1, 8'h5A, 1'b0, 1'b1, 1'b0, 1'b0},  // R5
    {2'd3, 1'b1, 1'b1, 8'h5A, 1'b1, 1'b1, 1'b1, 1'b0},  // R6
    {2'd3, 1'b1, 1'b1, 8'h5B, 1'b1, 1'b1, 1'b0, 1'b0},  // R6
    {2'd1, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b0},  // R7
    {2'd0, 1'b0, 1'b1, 8'h66, 1'b0, 1'b1, 1'b0, 1'b0},  // R7
    {2'd2, 1'b1, 1'b1, 8'hA5, 1'b1, 1'b0, 1'b0, 1'b1}   // R6 R8
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic holdBit(input logic v, input bit glitch);
    for (int c = 0; c < BITCLK; c++) begin
      rxIn = (glitch && c >= 30 && c < 34) ? ~v : v;
      @(negedge clk);
    end
  endtask

  task automatic sendFrame(input bit nine, input logic [7:0] d, input logic b9,
                           input logic stp, input int glitchBit);
    holdBit(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) holdBit(d[i], glitchBit == i);
    if (nine) holdBit(b9, 1'b0);
    holdBit(stp, 1'b0);
    holdBit(1'b1, 1'b0);
  endtask

  task automatic clearFlags();
    doneClr = 1'b1; ferrClr = 1'b1;
    @(negedge clk);
    doneClr = 1'b0; ferrClr = 1'b0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R12
    check("R12 rxData", {8'h0, rxData}, 16'h0000);
    check("R12 flags", {13'h0, rxBit9, rxDone, frameErr}, 16'h0000);
    rstN = 1'b1;
    repeat (BITCLK) @(negedge clk);

    for (int v = 0; v < 12; v++) begin
      logic [15:0] e;
      e = VEC[v];
      modeSel = e[15:14]; mpFilter = e[13]; rxEnable = e[12];
      clearFlags();
      sendFrame(e[15], e[11:4], e[3], e[2], -1);
      if (e[1]) begin
        mData = e[11:4];
        mB9   = e[15] ? e[3] : e[2];
      end
      check($sformatf("R1-vec%0d rxDone", v), {15'h0, rxDone}, {15'h0, e[1]});
      check($sformatf("R2-vec%0d rxData", v), {8'h0, rxData}, {8'h0, mData});
      check($sformatf("R3-vec%0d rxBit9", v), {15'h0, rxBit9}, {15'h0, mB9});
      check($sformatf("R8-vec%0d frameErr", v), {15'h0, frameErr}, {15'h0, e[0]});
    end

    // R9: overwrite while done is set
    modeSel = 2'd1; mpFilter = 1'b0; rxEnable = 1'b1;
    clearFlags();
    sendFrame(1'b0, 8'h11, 1'b0, 1'b1, -1);
    sendFrame(1'b0, 8'h22, 1'b0, 1'b1, -1);
    check("R9 done kept", {15'h0, rxDone}, 16'h0001);
    check("R9 overwrite", {8'h0, rxData}, 16'h0022);
    clearFlags();
    check("R9 cleared", {15'h0, rxDone}, 16'h0000);

    // R8: sticky framing error across a good frame
    sendFrame(1'b0, 8'h33, 1'b0, 1'b0, -1);
    sendFrame(1'b0, 8'h44, 1'b0, 1'b1, -1);
    check("R8 sticky", {15'h0, frameErr}, 16'h0001);
    ferrClr = 1'b1; @(negedge clk); ferrClr = 1'b0;
    check("R8 cleared", {15'h0, frameErr}, 16'h0000);

    // R10: one-tick glitch in the middle of data bit 3
    clearFlags();
    sendFrame(1'b0, 8'hF0, 1'b0, 1'b1, 3);
    check("R10 vote", {8'h0, rxData}, 16'h00F0);
    check("R10 done", {15'h0, rxDone}, 16'h0001);

    // R11: short low pulse is not a frame
    clearFlags();
    rxIn = 1'b0; repeat (16) @(negedge clk);
    rxIn = 1'b1; repeat (12 * BITCLK) @(negedge clk);
    check("R11 no done", {15'h0, rxDone}, 16'h0000);
    check("R11 data kept", {8'h0, rxData}, 16'h00F0);
    check("R11 no ferr", {15'h0, frameErr}, 16'h0000);

    // R7: enable dropped mid-frame aborts it
    clearFlags();
    fork
      sendFrame(1'b0, 8'h99, 1'b0, 1'b1, -1);
      begin repeat (4 * BITCLK) @(negedge clk); rxEnable = 1'b0;
            @(negedge clk); rxEnable = 1'b1; end
    join
    repeat (BITCLK) @(negedge clk);
    check("R7 abort done", {15'h0, rxDone}, 16'h0000);
    check("R7 abort data", {8'h0, rxData}, 16'h00F0);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule